// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Controller

This block watches 32 already-synchronized GPIO input levels and turns selected transitions or levels into interrupt requests. Each pin has a 4-bit sense code. The code selects one of five detection kinds: rising edge, falling edge, high level, low level or either edge. A detected event sets a sticky pending bit. Software clears that bit by writing ones.

A 32-bit register bus holds the configuration and the status views. It carries a read/write accept mask that gates detection for each pin. Enable bits are set and cleared through separate write-one strobes. Two status views are readable: the raw pending vector and the pending vector with the enable mask applied. The enabled pending bits are merged into two interrupt lines, one for pins 0 to 15 and one for pins 16 to 31. A service routine reads the masked view, handles the lowest set bit, clears it, and repeats until the view reads zero.

Top module: `pin_irq_sense`

## Requirements
- R1: After reset the accept mask, the enable mask, all pending bits and all sense codes are zero, and both interrupt outputs are low.
- R2: The sense code of pin p sits in the word at byte address 0x40 + 4*(p/8), in bits 4*(p%8)+3 down to 4*(p%8). That word reads back what was written.
- R3: Sense codes are decoded as follows:
  - 0x8 detects a rising edge.
  - 0x9 detects a falling edge.
  - 0xA detects a high level.
  - 0xB detects a low level.
  - 0xC detects either edge.
  - Every other code, including all codes with bit 3 clear, detects nothing.
  - An edge is found by comparing the current input with its value one cycle earlier. The pending bit sets at the first clock edge that samples the new input level.
- R4: The accept mask at 0x14 is read/write. A pin whose accept bit is 0 never gets its pending bit set.
- R5: Writing ones to 0x18 sets the matching enable bits. Zero bits in the write leave enables unchanged. Reading 0x18 returns the enable mask.
- R6: Writing ones to 0x1C clears the matching enable bits. Zero bits in the write leave enables unchanged. Reading 0x1C also returns the enable mask.
- R7: Reading 0x20 returns the pending vector whatever the enable mask holds.
- R8: Reading 0x24 returns the pending vector ANDed with the enable mask.
- R9: Writing ones to 0x28 clears the matching pending bits. If a new event on a pin arrives in the same cycle as its clear, the pending bit stays set.
- R10: In a level sense mode, a clear has no lasting effect while the sensed level persists. Once the level is gone, a clear takes effect.
- R11: The low interrupt output is the OR of masked status bits 15:0. The high output is the OR of bits 31:16. Both follow register state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | N_PINS | Synchronized GPIO input levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_lo | output | 1 | Interrupt request for pins 0..15 |
| irq_hi | output | 1 | Interrupt request for pins 16..31 |

## Verification
Any corrupted state inside the block becomes visible at the ports within one cycle:
- A wrong previous-value register or a wrong sense decode produces a pending bit that appears, or fails to appear, at the raw status address on the cycle after the input changes.
- A broken enable or clear path shows up at once in the masked status and on the interrupt lines, because both are combinational views of the stored bits.
- A field decoded at the wrong position shows up either as a wrong readback of the sense word or as detection on a neighbouring pin.

// File: rtl/pin_irq_sense.sv
module pin_irq_sense #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int HALF   = N_PINS / 2;
  localparam int N_MREG = N_PINS / 8;
  localparam logic [ADDR_W-1:0] A_ACC  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_ECLR = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_MST  = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_PCLR = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8'h40);

  logic [N_PINS-1:0] acc_q, en_q, pend_q, prev_q, evt;
  logic [3:0]        mode_q [N_PINS];
  logic [31:0]       mode_word [N_MREG];
  logic [N_PINS-1:0] wbits;

  assign wbits = bus_wdata[N_PINS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      en_q   <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= pin_in;
      if (bus_we && bus_addr == A_ACC)  acc_q <= wbits;
      if (bus_we && bus_addr == A_ESET) en_q  <= en_q | wbits;
      if (bus_we && bus_addr == A_ECLR) en_q  <= en_q & ~wbits;
    end
  end

  logic [N_PINS-1:0] clr;
  assign clr = (bus_we && bus_addr == A_PCLR) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | evt;
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    localparam int R = p / 8;
    localparam int F = 4 * (p % 8);
    logic hit;

    always_ff @(posedge clk) begin
      if (!rst_n) mode_q[p] <= 4'h0;
      else if (bus_we && bus_addr == A_MODE + ADDR_W'(4 * R))
        mode_q[p] <= bus_wdata[F +: 4];
    end

    always_comb begin
      case (mode_q[p])
        4'h8:    hit = pin_in[p] & ~prev_q[p];
        4'h9:    hit = ~pin_in[p] & prev_q[p];
        4'hA:    hit = pin_in[p];
        4'hB:    hit = ~pin_in[p];
        4'hC:    hit = pin_in[p] ^ prev_q[p];
        default: hit = 1'b0;
      endcase
    end

    assign evt[p] = acc_q[p] & hit;
  end

  for (genvar r = 0; r < N_MREG; r++) begin : g_word
    for (genvar k = 0; k < 8; k++) begin : g_fld
      assign mode_word[r][4*k +: 4] = mode_q[8*r + k];
    end
  end

  logic [N_PINS-1:0] mst;
  assign mst = pend_q & en_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ACC:          bus_rdata = 32'(acc_q);
      A_ESET, A_ECLR: bus_rdata = 32'(en_q);
      A_RAW:          bus_rdata = 32'(pend_q);
      A_MST:          bus_rdata = 32'(mst);
      default: begin
        for (int r = 0; r < N_MREG; r++)
          if (bus_addr == A_MODE + ADDR_W'(4 * r)) bus_rdata = mode_word[r];
      end
    endcase
  end

  assign irq_lo = |mst[HALF-1:0];
  assign irq_hi = |mst[N_PINS-1:HALF];
endmodule

module pin_irq_sense_chk #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [N_PINS-1:0] acc,
  input logic [N_PINS-1:0] en,
  input logic [N_PINS-1:0] pend,
  input logic              irq_lo,
  input logic              irq_hi
);
  a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pend == '0 && en == '0 && acc == '0));

  a_r5_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8'h18)) |=>
      ((en & $past(bus_wdata[N_PINS-1:0])) == $past(bus_wdata[N_PINS-1:0])));

  a_r6_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8'h1C)) |=>
      ((en & $past(bus_wdata[N_PINS-1:0])) == '0));

  a_r4_accept_gate: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(acc)) == '0));

  a_r9_clear_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8'h28)) |=>
      ((pend & $past(bus_wdata[N_PINS-1:0]) & ~$past(acc)) == '0));

  a_r11_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (!irq_lo && !irq_hi));
endmodule

bind pin_irq_sense pin_irq_sense_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .acc(acc_q), .en(en_q), .pend(pend_q),
  .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/pin_irq_sense_test.sv
module pin_irq_sense_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pin_irq_sense uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // {code[7:4], sel pin20[3], start level[2], end level[1], expected[0]}
  localparam logic [7:0] VEC [14] = '{
    {4'h8, 4'b0011}, {4'h8, 4'b0100}, {4'h9, 4'b1101}, {4'h9, 4'b1010},
    {4'hA, 4'b0011}, {4'hA, 4'b1100}, {4'hB, 4'b1101}, {4'hB, 4'b0010},
    {4'hC, 4'b0101}, {4'hC, 4'b1011}, {4'hC, 4'b0110}, {4'h0, 4'b1010},
    {4'hD, 4'b0010}, {4'h3, 4'b1100}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h20, d); chk("R1 raw", d, 0);
    rd(8'h24, d); chk("R1 masked", d, 0);
    rd(8'h18, d); chk("R1 enable", d, 0);
    rd(8'h14, d); chk("R1 accept", d, 0);
    rd(8'h4C, d); chk("R1 mode", d, 0);
    chk("R1 irq", {30'd0, irq_hi, irq_lo}, 0);

    // R3 sense codes via table
    for (int i = 0; i < 14; i++) begin
      int pin;
      logic [7:0] ra;
      pin = VEC[i][3] ? 20 : 5;
      ra = 8'h40 + 8'(4 * (pin / 8));
      wr(8'h14, 0);
      wr(ra, 32'(VEC[i][7:4]) << (4 * (pin % 8)));
      pins[pin] = VEC[i][2];
      tick(); tick();
      wr(8'h28, 32'hFFFF_FFFF);
      wr(8'h14, 32'd1 << pin);
      pins[pin] = VEC[i][1];
      tick();
      rd(8'h20, d);
      chk($sformatf("R3 vector %0d", i), (d >> pin) & 1, 32'(VEC[i][0]));
    end
    wr(8'h40, 0); wr(8'h48, 0); wr(8'h28, 32'hFFFF_FFFF);
    pins = '0; tick();

    // R2 field position: pin 10 in word 0x44 bits 11:8
    wr(8'h44, 32'h0000_0800);
    rd(8'h44, d); chk("R2 readback", d, 32'h0000_0800);
    wr(8'h14, 32'h0000_0C00);
    pins[10] = 1; pins[11] = 1;
    tick();
    rd(8'h20, d); chk("R2 only pin10 detects", d, 32'h0000_0400);
    rd(8'h14, d); chk("R4 accept readback", d, 32'h0000_0C00);

    // R4 accept gate: pin 10 with accept off
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h14, 0);
    pins[10] = 0; tick(); pins[10] = 1; tick();
    rd(8'h20, d); chk("R4 gated", d, 0);
    wr(8'h44, 0); pins = '0;

    // R9 clear and event in the same cycle on pin 5 rising
    wr(8'h40, 32'h0080_0000);
    wr(8'h14, 32'h20);
    tick();
    wr(8'h28, 32'hFFFF_FFFF);
    pins[5] = 1;
    wr(8'h28, 32'h20);
    rd(8'h20, d); chk("R9 event wins over clear", d, 32'h20);
    wr(8'h28, 32'h20);
    rd(8'h20, d); chk("R9 clear", d, 0);

    // R5 R8 R11 enable and masked status
    pins[5] = 0; tick(); pins[5] = 1; tick();
    rd(8'h24, d); chk("R8 masked without enable", d, 0);
    chk("R11 low idle", {31'd0, irq_lo}, 0);
    wr(8'h18, 32'h20);
    rd(8'h18, d); chk("R5 enable set", d, 32'h20);
    rd(8'h24, d); chk("R8 masked", d, 32'h20);
    chk("R11 irq_lo", {30'd0, irq_hi, irq_lo}, 32'd1);
    wr(8'h18, 32'h0);
    rd(8'h1C, d); chk("R5 zero write", d, 32'h20);
    wr(8'h1C, 32'h20);
    rd(8'h18, d); chk("R6 enable clear", d, 0);
    rd(8'h20, d); chk("R7 raw unaffected", d, 32'h20);
    chk("R11 irq_lo off", {31'd0, irq_lo}, 0);
    wr(8'h28, 32'h20);

    // R11 high half: pin 20 high level in word 0x48 bits 19:16
    wr(8'h48, 32'h000A_0000);
    wr(8'h14, 32'h0010_0000);
    wr(8'h18, 32'h0010_0000);
    pins[20] = 1; tick();
    chk("R11 irq_hi", {30'd0, irq_hi, irq_lo}, 32'd2);
    // R10 level persists
    wr(8'h28, 32'h0010_0000);
    rd(8'h20, d); chk("R10 level holds", d, 32'h0010_0000);
    pins[20] = 0; tick();
    wr(8'h28, 32'h0010_0000);
    rd(8'h20, d); chk("R10 clear after level gone", d, 0);
    chk("R11 irq_hi off", {31'd0, irq_hi}, 0);
    wr(8'h1C, 32'hFFFF_FFFF);

    // R8 lowest-first service loop: pins 3 and 9 rising
    wr(8'h40, 32'h0000_8000);
    wr(8'h44, 32'h0000_0080);
    wr(8'h14, 32'h0000_0208);
    wr(8'h18, 32'h0000_0208);
    pins[3] = 1; pins[9] = 1; tick();
    rd(8'h24, d); chk("R8 two pending", d, 32'h0000_0208);
    wr(8'h28, 32'h8);
    rd(8'h24, d); chk("R9 lowest cleared", d, 32'h0000_0200);
    wr(8'h28, 32'h200);
    rd(8'h24, d); chk("R9 all serviced", d, 0);
    chk("R11 quiet", {30'd0, irq_hi, irq_lo}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule